// File: doc/BRIEF.md
# Banked Interrupt Vector Controller

This block gathers a large set of edge-signalled interrupt vectors and presents them to a parent interrupt controller as one level-sensitive line per bank. Vectors come in banks of 32, and there are one to eight banks, so up to 256 vectors. Vector n belongs to bank n/32 and sits at bit n%32 of that bank's words. Every vector has a latched cause bit and an enable bit. A bank's line is raised while any vector in it is both pending and enabled.

Software works through a 32-bit register port. Reading a cause word shows which vectors are pending. Writing ones to a cause word acknowledges those vectors and leaves the zero-written bits alone. Enable words read back exactly what was last written, so software can mask or unmask a single vector by read-modify-write. Cause words start at byte offset 0x00 (bank i at 4*i). Enable words start at 0x20 (bank i at 0x20 + 4*i).

Top module: `vec_bank_intc`

## Requirements
- R1: Synchronous active-high reset clears every cause and enable bit and sets `rdata` to 0. After reset, every register reads as 0 and every `bank_irq` bit is low.
- R2: A 0-to-1 change of `vec_in[n]` between two clock edges sets the cause bit at bit n%32 of the word at offset 4*(n/32) on the second edge. An input held high causes no further set once its bit is cleared. An input already high when reset is released counts as no edge.
- R3: A write to a cause word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: Writing 0xFFFFFFFF to a cause word clears every pending bit of that bank and leaves the other banks unchanged.
- R5: A write to the enable word at offset 0x20 + 4*i stores the written value, and a later read returns it. An enable word that is not written keeps its value.
- R6: `bank_irq[i]` is high exactly when the bitwise AND of bank i's cause word and enable word is non-zero. Cause bits latch whether or not the vector is enabled, so unmasking a vector that is already pending raises the line.
- R7: When a new edge on a vector arrives in the same cycle as a write that clears that vector's bit, the bit ends up set.
- R8: Offsets with `addr[1:0]` not zero, or with `addr` at 0x40 or above, read as 0. Writes to those offsets change no register.
- R9: Parameter `NUM_BANKS` (1 to 8) sets the number of banks. The cause and enable offsets of absent banks read as 0, and writes to them are ignored.
- R10: `rdata` is loaded at the clock edge that samples `rd_en` high and holds its value otherwise. A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_in | input | NUM_BANKS*32 | Interrupt vector inputs; a rising edge marks an event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bank_irq | output | NUM_BANKS | Per-bank level output to the parent controller |

## Verification
The critical overlap is a fresh edge on a vector landing in the same cycle as a software write that clears that vector. The bench forces this case directly: it drops an input for one cycle, then raises it in the same cycle as a write-one-to-clear of its bit, and checks by reading the cause word that the bit stayed set. A second overlap is a read and a write to the same register in one cycle, which must return the old value. Long random traffic produces both collisions again, together with all-ones clears. A behavioural model checks every cycle, and a second instance with three banks checks the absent-bank offsets.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
    localparam int WORD_W     = 32;
    localparam int MAX_BANKS  = 8;
    localparam int ADDR_W     = 8;
    localparam int BANK_IDX_W = $clog2(MAX_BANKS);

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_ENABLE = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e               kind;
        logic [BANK_IDX_W-1:0]   bank;
    } reg_sel_t;

    // Offset map: bit 5 picks enable vs cause, bits 4:2 pick the bank.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int nbanks);
        reg_sel_t s;
        s.kind = SEL_NONE;
        s.bank = a[4:2];
        if (a[1:0] == 2'b00 && a[7:6] == 2'b00 && int'(a[4:2]) < nbanks)
            s.kind = a[5] ? SEL_ENABLE : SEL_CAUSE;
        return s;
    endfunction
endpackage

// File: rtl/vbi_edge_detect.sv
module vbi_edge_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] din_q;

    // Tracks the input during reset too, so a level held through reset is no edge.
    always_ff @(posedge clk) begin
        din_q <= din;
    end

    assign rise = rst ? '0 : (din & ~din_q);
endmodule

// File: rtl/vbi_bank.sv
module vbi_bank
    import vbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rise,
    input  logic              clr_en,
    input  logic              en_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cause,
    output logic [WORD_W-1:0] enable,
    output logic              irq
);
    logic [WORD_W-1:0] clr_mask;

    assign clr_mask = clr_en ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause  <= '0;
            enable <= '0;
        end else begin
            cause <= (cause & ~clr_mask) | rise;
            if (en_wr)
                enable <= wdata;
        end
    end

    assign irq = |(cause & enable);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((cause & $past(rise)) == $past(rise)))
        else $error("new edge lost"); // R7

    AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((cause & $past(cause & ~wdata)) == $past(cause & ~wdata)))
        else $error("zero-written cause bit changed"); // R3

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (clr_en && wdata == '1 && rise == '0) |=> (cause == '0))
        else $error("all-ones write left bits pending"); // R4

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(enable))
        else $error("enable moved without write"); // R5

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (enable == $past(wdata)))
        else $error("enable did not load"); // R5

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq)
        else $error("line high while fully masked"); // R6
endmodule

// File: rtl/vbi_read_port.sv
module vbi_read_port
    import vbi_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BANKS*WORD_W-1:0] cause_flat,
    input  logic [NUM_BANKS*WORD_W-1:0] enable_flat,
    output logic [WORD_W-1:0]           rdata
);
    reg_sel_t          sel;
    logic [WORD_W-1:0] rd_word;

    assign sel = decode_addr(addr, NUM_BANKS);

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (sel.bank == BANK_IDX_W'(i)) begin
                if (sel.kind == SEL_ENABLE)
                    rd_word = enable_flat[i*WORD_W +: WORD_W];
                else if (sel.kind == SEL_CAUSE)
                    rd_word = cause_flat[i*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_word;
    end

    AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel.kind == SEL_NONE) |=> (rdata == '0))
        else $error("unmapped offset returned data"); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata))
        else $error("rdata changed without read"); // R10
endmodule

// File: rtl/vec_bank_intc.sv
module vec_bank_intc
    import vbi_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*WORD_W-1:0] vec_in,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [WORD_W-1:0]           wdata,
    output logic [WORD_W-1:0]           rdata,
    output logic [NUM_BANKS-1:0]        bank_irq
);
    localparam int VEC_W = NUM_BANKS * WORD_W;

    reg_sel_t          wsel;
    logic [VEC_W-1:0]  rise_flat;
    logic [VEC_W-1:0]  cause_flat;
    logic [VEC_W-1:0]  enable_flat;

    assign wsel = decode_addr(addr, NUM_BANKS);

    vbi_edge_detect #(.WIDTH(VEC_W)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (vec_in),
        .rise (rise_flat)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic clr_en;
        logic en_wr;

        assign clr_en = wr_en && wsel.kind == SEL_CAUSE  && wsel.bank == BANK_IDX_W'(b);
        assign en_wr  = wr_en && wsel.kind == SEL_ENABLE && wsel.bank == BANK_IDX_W'(b);

        vbi_bank u_bank (
            .clk    (clk),
            .rst    (rst),
            .rise   (rise_flat[b*WORD_W +: WORD_W]),
            .clr_en (clr_en),
            .en_wr  (en_wr),
            .wdata  (wdata),
            .cause  (cause_flat[b*WORD_W +: WORD_W]),
            .enable (enable_flat[b*WORD_W +: WORD_W]),
            .irq    (bank_irq[b])
        );
    end

    vbi_read_port #(.NUM_BANKS(NUM_BANKS)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .addr        (addr),
        .cause_flat  (cause_flat),
        .enable_flat (enable_flat),
        .rdata       (rdata)
    );

    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (cause_flat == '0) |-> (bank_irq == '0))
        else $error("line high with nothing pending"); // R6
endmodule

// File: tb/tb_vec_bank_intc.sv
module tb_vec_bank_intc;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 8;
    localparam int NB_S = 3;
    localparam int W    = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NB*W-1:0]   vec = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [7:0]        addr  = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata, rdata_s;
    logic [NB-1:0]     irq;
    logic [NB_S-1:0]   irq_s;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    run_chk = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_bank_intc #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst(rst), .vec_in(vec), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .bank_irq(irq)
    );

    vec_bank_intc #(.NUM_BANKS(NB_S)) dut_small (
        .clk(clk), .rst(rst), .vec_in(vec[NB_S*W-1:0]), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_s), .bank_irq(irq_s)
    );

    // Behavioural reference model
    logic [31:0]     m_cause [NB];
    logic [31:0]     m_en    [NB];
    logic [31:0]     m_rd, m_rd_s;
    logic [NB*W-1:0] m_prev;

    function automatic logic [31:0] m_read(input logic [7:0] a, input int nb);
        int b;
        if (a[1:0] != 2'b00 || a >= 8'h40) return 32'h0;
        b = int'(a[4:2]);
        if (b >= nb) return 32'h0;
        return a[5] ? m_en[b] : m_cause[b];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                m_cause[b] = '0;
                m_en[b]    = '0;
            end
            m_rd   = '0;
            m_rd_s = '0;
        end else begin
            if (rd_en) begin
                m_rd   = m_read(addr, NB);
                m_rd_s = m_read(addr, NB_S);
            end
            for (int b = 0; b < NB; b++) begin
                logic [31:0] rs, clr;
                rs  = vec[b*W +: W] & ~m_prev[b*W +: W];
                clr = (wr_en && addr == 8'(4*b)) ? wdata : 32'h0;
                m_cause[b] = (m_cause[b] & ~clr) | rs;
                if (wr_en && addr == 8'(32 + 4*b))
                    m_en[b] = wdata;
            end
        end
        m_prev = vec;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (run_chk && !rst) begin
            for (int b = 0; b < NB; b++)
                chk({cur_req, " R6 irq"}, 32'(irq[b]), 32'(|(m_cause[b] & m_en[b])));
            for (int b = 0; b < NB_S; b++)
                chk({cur_req, " R9 irq small"}, 32'(irq_s[b]), 32'(|(m_cause[b] & m_en[b])));
            chk({cur_req, " R10 rdata"}, rdata, m_rd);
            chk({cur_req, " R9 rdata small"}, rdata_s, m_rd_s);
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 irq in reset", 32'(irq), 32'h0);
        chk("R1 rdata in reset", rdata, 32'h0);
        vec[70] = 1'b1;              // held high across reset release
        @(negedge clk);
        rst = 1'b0;
        run_chk = 1'b1;
        for (int a = 0; a < 64; a += 4)
            rd_chk("R1 reset read", 8'(a), 32'h0);
        rd_chk("R2 high through reset", 8'h08, 32'h0);

        cur_req = "R2";
        vec[5] = 1'b1; vec[40] = 1'b1; vec[255] = 1'b1;
        @(negedge clk);
        rd_chk("R2 bank0", 8'h00, 32'h0000_0020);
        rd_chk("R2 bank1", 8'h04, 32'h0000_0100);
        rd_chk("R2 bank7", 8'h1C, 32'h8000_0000);
        chk("R6 latched while masked", 32'(irq), 32'h0);
        bus_wr(8'h00, 32'h0000_0020);
        @(negedge clk);
        rd_chk("R2 held level no reset", 8'h00, 32'h0);

        cur_req = "R3";
        bus_wr(8'h04, 32'h0);
        rd_chk("R3 zero write keeps", 8'h04, 32'h0000_0100);
        bus_wr(8'h04, 32'h0000_0001);
        rd_chk("R3 other bit keeps", 8'h04, 32'h0000_0100);

        cur_req = "R5";
        bus_wr(8'h24, 32'h0000_0100);
        rd_chk("R5 readback", 8'h24, 32'h0000_0100);
        chk("R6 unmask pending", 32'(irq), 32'h02);
        bus_wr(8'h3C, 32'h8000_0000);
        chk("R6 bank7 line", 32'(irq), 32'h82);
        bus_wr(8'h24, 32'h0);
        chk("R6 mask drops line", 32'(irq), 32'h80);
        rd_chk("R6 cause survives mask", 8'h04, 32'h0000_0100);

        cur_req = "R4";
        bus_wr(8'h1C, 32'hFFFF_FFFF);
        chk("R4 line low", 32'(irq), 32'h0);
        rd_chk("R4 bank cleared", 8'h1C, 32'h0);
        rd_chk("R4 other bank kept", 8'h04, 32'h0000_0100);

        cur_req = "R7";
        vec[35] = 1'b1;
        @(negedge clk);
        vec[35] = 1'b0;
        @(negedge clk);
        vec[35] = 1'b1;
        bus_wr(8'h04, 32'h0000_0008);
        rd_chk("R7 set wins over clear", 8'h04, 32'h0000_0108);
        bus_wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R7 clear without edge", 8'h04, 32'h0);

        cur_req = "R8";
        bus_wr(8'h24, 32'h5A5A_0000);
        bus_wr(8'h40, 32'hFFFF_FFFF);
        bus_wr(8'h25, 32'h0);
        bus_wr(8'hA4, 32'h0);
        bus_wr(8'h27, 32'h0);
        rd_chk("R8 enable untouched", 8'h24, 32'h5A5A_0000);
        rd_chk("R8 offset 0x40", 8'h40, 32'h0);
        rd_chk("R8 offset 0x25", 8'h25, 32'h0);
        rd_chk("R8 offset 0xFF", 8'hFF, 32'h0);

        cur_req = "R9";
        bus_wr(8'h2C, 32'h0000_00FF);
        rd_chk("R9 present bank", 8'h2C, 32'h0000_00FF);
        chk("R9 absent bank small", rdata_s, 32'h0);
        bus_wr(8'h28, 32'h0000_0F00);
        rd_chk("R9 bank2 big", 8'h28, 32'h0000_0F00);
        chk("R9 bank2 small", rdata_s, 32'h0000_0F00);

        cur_req = "R10";
        rd_en = 1'b1; wr_en = 1'b1; addr = 8'h30; wdata = 32'h0000_1234;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R10 read before write", rdata, 32'h0);
        rd_chk("R10 new value", 8'h30, 32'h0000_1234);
        addr = 8'h00;
        repeat (2) @(negedge clk);
        chk("R10 rdata holds", rdata, 32'h0000_1234);

        cur_req = "R6 random";
        for (int c = 0; c < 3000; c++) begin
            for (int k = 0; k < 4; k++)
                vec[$urandom_range(NB*W-1)] ^= 1'b1;
            wr_en = ($urandom_range(3) == 0);
            rd_en = ($urandom_range(1) == 0);
            if ($urandom_range(7) == 0)
                addr = 8'($urandom_range(255));
            else
                addr = 8'(4 * $urandom_range(15));
            wdata = ($urandom_range(5) == 0) ? 32'hFFFF_FFFF : $urandom;
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        run_chk = 1'b0;
        finish_run();
    end
endmodule